// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block runs erase and program operations on a 32-bit flash bank made of two 16-bit NOR devices wired side by side. A client asks for either a sector erase or a single-word program through a request port. The block then issues the unlock and command write cycles on a synchronous memory master port and polls the status that both devices return. Each 16-bit half is tracked on its own until both have finished or one has reported a failure. The block then puts the bank back in read-array mode and reports a two-bit result code with a one-cycle done pulse.

A program request first reads the target word and refuses to continue if the new data would need any bit to go from 0 to 1. A program that completes is checked by reading the word back. Polling is limited by a cycle-count timeout that starts when the last command write has been issued.

Top module: `nor_cmd_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, req_busy, req_done, mem_we and mem_re are all 0.
- R2: Every command write carries its command byte in bits 7:0 and in bits 23:16 and zeros elsewhere. The first unlock write puts 0xAA at byte address 0x1554 (word 0x555 shifted left by 2), and the second puts 0x55 at byte address 0xAA8 (word 0x2AA).
- R3: An erase (req_op = 0) writes, in this order: 0xAA, 0x55, 0x80 at 0x1554, 0xAA, 0x55, and then 0x30 at the sector address.
- R4: A program (req_op = 1) first reads the target. The target is req_addr with bits 1:0 cleared. If (read & req_data) != req_data, the block writes nothing and ends with result 3. Otherwise it writes 0xAA, 0x55, 0x20 at 0x1554, then 0xA0 at the target, then req_data at the target.
- R5: During erase polling, a half whose bit 7 reads 1 is complete, and otherwise a half whose bit 5 reads 1 has failed. A half keeps its first outcome. Polling continues until both halves are resolved, and a failure gives result 1.
- R6: During program polling, a half is complete when its bit 7 equals bit 7 of that half of req_data. If it does not match and its bit 5 is 1, the block reads the word once more. The half fails only if bit 7 still does not match on that second read.
- R7: The timeout counter starts when polling begins. If a status check finds that TIMEOUT_CYC cycles have passed, the block writes 0xF0 to the target and ends with result 2 within TIMEOUT_CYC+6 cycles of the last command write.
- R8: When polling ends, the block writes read-array 0xF0 (replicated) at the target. A program then reads the target back and ends with result 1 if the value differs from req_data or if a half failed.
- R9: The result codes are 0 = ok, 1 = device error, 2 = timeout and 3 = not erased. req_done is high for exactly one cycle, and req_result is valid in that cycle.
- R10: req_busy rises the cycle after an accepted start. A start that arrives while req_busy is high is ignored.
- R11: Read data is sampled in the cycle after mem_re is asserted. Each status check uses exactly one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Start pulse, accepted when idle |
| req_op | input | 1 | 0 = sector erase, 1 = word program |
| req_addr | input | ADDR_W | Byte address of the sector or target word |
| req_data | input | DATA_W | Data word to program |
| req_busy | output | 1 | Operation in progress |
| req_done | output | 1 | One-cycle completion pulse |
| req_result | output | 2 | Result code |
| mem_addr | output | ADDR_W | Byte address on the memory port |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after mem_re |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |

## Verification
The hardest case to reach is a program in which one half raises its error bit while the other half is still busy. That forces a confirming read that resolves only the flagged half, after which normal polling has to resume for the other half. The bench reaches this case with a scripted flash model that returns a chosen word for each read. The scripts also set up halves that finish in different polls, a confirming read that clears the suspected error, and a status that never completes so that the timeout fires.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_PRE_RD, S_PRE_CHK, S_CMD, S_POLL_RD, S_POLL_CHK,
        S_RECHK_RD, S_RECHK_CHK, S_RST_WR, S_VER_RD, S_VER_CHK, S_FINISH
    } seq_state_e;

    typedef enum logic [1:0] {H_PEND, H_RECHK, H_DONE, H_FAIL} half_st_e;

    typedef enum logic [1:0] {
        RES_OK = 2'd0, RES_DEVERR = 2'd1, RES_TIMEOUT = 2'd2, RES_NOTERASED = 2'd3
    } res_e;

    localparam logic [7:0] CB_UNLOCK_A   = 8'hAA;
    localparam logic [7:0] CB_UNLOCK_B   = 8'h55;
    localparam logic [7:0] CB_ERASE_ARM  = 8'h80;
    localparam logic [7:0] CB_ERASE_GO   = 8'h30;
    localparam logic [7:0] CB_BYPASS     = 8'h20;
    localparam logic [7:0] CB_PROG       = 8'hA0;
    localparam logic [7:0] CB_READ_ARRAY = 8'hF0;

    localparam int OFS_A = 'h555;
    localparam int OFS_B = 'h2AA;
endpackage

// File: rtl/nor_half_eval.sv
module nor_half_eval
    import nor_seq_pkg::*;
(
    input  logic     is_prog,
    input  logic     recheck_pass,
    input  half_st_e st_in,
    input  logic     rd_ready,
    input  logic     rd_fail,
    input  logic     wd_ready,
    output half_st_e st_out
);
    always_comb begin
        st_out = st_in;
        if (recheck_pass) begin
            if (st_in == H_RECHK)
                st_out = (rd_ready == wd_ready) ? H_DONE : H_FAIL;
        end else if (st_in == H_PEND) begin
            if (!is_prog) begin
                if (rd_ready)     st_out = H_DONE;
                else if (rd_fail) st_out = H_FAIL;
            end else begin
                if (rd_ready == wd_ready) st_out = H_DONE;
                else if (rd_fail)         st_out = H_RECHK;
            end
        end
    end
endmodule

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q >= CNT_W'(LIMIT));

    always_comb begin
        cnt_d = cnt_q;
        if (arm)                cnt_d = '0;
        else if (run && !expired) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int DATA_W      = 32,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic              req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_busy,
    output logic              req_done,
    output logic [1:0]        req_result,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic              mem_re
);
    localparam int HALF_W = 16;
    localparam int NHALF  = DATA_W / HALF_W;
    localparam int STEP_W = 3;
    localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(OFS_A << 2);
    localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(OFS_B << 2);

    typedef struct packed {
        seq_state_e              st;
        logic                    op;
        logic [ADDR_W-1:0]       addr;
        logic [DATA_W-1:0]       data;
        logic [STEP_W-1:0]       step;
        half_st_e [NHALF-1:0]    half;
        res_e                    res;
    } ctx_t;

    ctx_t d, q;

    function automatic logic [DATA_W-1:0] cmd_word(input logic [7:0] b);
        logic [DATA_W-1:0] w;
        for (int h = 0; h < NHALF; h++)
            w[h*HALF_W +: HALF_W] = {{(HALF_W-8){1'b0}}, b};
        return w;
    endfunction

    half_st_e half_nx [NHALF];
    logic     tmr_arm, tmr_run, tmr_expired;

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        nor_half_eval u_eval (
            .is_prog      (q.op),
            .recheck_pass (q.st == S_RECHK_CHK),
            .st_in        (q.half[h]),
            .rd_ready     (mem_rdata[h*HALF_W + 7]),
            .rd_fail      (mem_rdata[h*HALF_W + 5]),
            .wd_ready     (q.data[h*HALF_W + 7]),
            .st_out       (half_nx[h])
        );
    end

    assign tmr_run = (q.st == S_POLL_RD) || (q.st == S_POLL_CHK) ||
                     (q.st == S_RECHK_RD) || (q.st == S_RECHK_CHK);

    nor_poll_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (tmr_arm),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    logic nx_all_res, nx_any_rechk, q_any_fail, last_step;

    always_comb begin
        nx_all_res   = 1'b1;
        nx_any_rechk = 1'b0;
        q_any_fail   = 1'b0;
        for (int h = 0; h < NHALF; h++) begin
            if (half_nx[h] == H_PEND || half_nx[h] == H_RECHK) nx_all_res = 1'b0;
            if (half_nx[h] == H_RECHK) nx_any_rechk = 1'b1;
            if (q.half[h] == H_FAIL)   q_any_fail   = 1'b1;
        end
        last_step = q.op ? (q.step == 3'd4) : (q.step == 3'd5);
    end

    always_comb begin
        d         = q;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = q.addr;
        mem_wdata = '0;
        tmr_arm   = 1'b0;
        unique case (q.st)
            S_IDLE: if (req_start) begin
                d.op   = req_op;
                d.addr = req_addr & ~ADDR_W'(3);
                d.data = req_data;
                d.step = '0;
                d.res  = RES_OK;
                for (int h = 0; h < NHALF; h++) d.half[h] = H_PEND;
                d.st   = req_op ? S_PRE_RD : S_CMD;
            end
            S_PRE_RD: begin
                mem_re = 1'b1;
                d.st   = S_PRE_CHK;
            end
            S_PRE_CHK: begin
                if ((mem_rdata & q.data) != q.data) begin
                    d.res = RES_NOTERASED;
                    d.st  = S_FINISH;
                end else begin
                    d.st  = S_CMD;
                end
            end
            S_CMD: begin
                mem_we = 1'b1;
                if (q.step == 3'd0 || (!q.op && q.step == 3'd3)) begin
                    mem_addr = ADR_A; mem_wdata = cmd_word(CB_UNLOCK_A);
                end else if (q.step == 3'd1 || (!q.op && q.step == 3'd4)) begin
                    mem_addr = ADR_B; mem_wdata = cmd_word(CB_UNLOCK_B);
                end else if (q.step == 3'd2) begin
                    mem_addr  = ADR_A;
                    mem_wdata = cmd_word(q.op ? CB_BYPASS : CB_ERASE_ARM);
                end else if (!q.op) begin
                    mem_wdata = cmd_word(CB_ERASE_GO);
                end else if (q.step == 3'd3) begin
                    mem_wdata = cmd_word(CB_PROG);
                end else begin
                    mem_wdata = q.data;
                end
                if (last_step) begin
                    tmr_arm = 1'b1;
                    d.st    = S_POLL_RD;
                end else begin
                    d.step  = q.step + 1'b1;
                end
            end
            S_POLL_RD: begin
                mem_re = 1'b1;
                d.st   = S_POLL_CHK;
            end
            S_POLL_CHK: begin
                if (tmr_expired) begin
                    d.res = RES_TIMEOUT;
                    d.st  = S_RST_WR;
                end else begin
                    for (int h = 0; h < NHALF; h++) d.half[h] = half_nx[h];
                    if (nx_any_rechk)    d.st = S_RECHK_RD;
                    else if (nx_all_res) d.st = S_RST_WR;
                    else                 d.st = S_POLL_RD;
                end
            end
            S_RECHK_RD: begin
                mem_re = 1'b1;
                d.st   = S_RECHK_CHK;
            end
            S_RECHK_CHK: begin
                for (int h = 0; h < NHALF; h++) d.half[h] = half_nx[h];
                d.st = nx_all_res ? S_RST_WR : S_POLL_RD;
            end
            S_RST_WR: begin
                mem_we    = 1'b1;
                mem_wdata = cmd_word(CB_READ_ARRAY);
                if (q.res == RES_TIMEOUT) begin
                    d.st = S_FINISH;
                end else begin
                    if (q_any_fail) d.res = RES_DEVERR;
                    d.st = q.op ? S_VER_RD : S_FINISH;
                end
            end
            S_VER_RD: begin
                mem_re = 1'b1;
                d.st   = S_VER_CHK;
            end
            S_VER_CHK: begin
                if (mem_rdata != q.data) d.res = RES_DEVERR;
                d.st = S_FINISH;
            end
            S_FINISH: d.st = S_IDLE;
            default:  d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= S_IDLE;
            q.op   <= 1'b0;
            q.addr <= '0;
            q.data <= '0;
            q.step <= '0;
            q.half <= '0;
            q.res  <= RES_OK;
        end else begin
            q <= d;
        end
    end

    assign req_busy   = (q.st != S_IDLE);
    assign req_done   = (q.st == S_FINISH);
    assign req_result = q.res;
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
    parameter int TIMEOUT_CYC = 100000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_start,
    input logic       req_op,
    input logic       req_busy,
    input logic       req_done,
    input logic [1:0] req_result,
    input logic       mem_we,
    input logic       mem_re
);
    logic op_q;
    int   busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= 1'b0;
            busy_cnt <= 0;
        end else begin
            if (req_start && !req_busy) op_q <= req_op;
            busy_cnt <= req_busy ? busy_cnt + 1 : 0;
        end
    end

    // R9: completion pulse lasts one cycle
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);

    // R11: never read and write in the same cycle
    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R1: memory port quiet while idle
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_busy |-> (!mem_we && !mem_re));

    // R10: accepted start raises busy next cycle
    assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start && !req_busy) |=> req_busy);

    // R4: not-erased code only appears for program requests
    assert_noterased_prog_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_done && !op_q) |-> (req_result != 2'd3));

    // R7: an operation never outlives the timeout by more than a fixed margin
    assert_bounded_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= TIMEOUT_CYC + 24);
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_start  (req_start),
    .req_op     (req_op),
    .req_busy   (req_busy),
    .req_done   (req_done),
    .req_result (req_result),
    .mem_we     (mem_we),
    .mem_re     (mem_re)
);

// File: tb/tb_nor_cmd_seq.sv
module tb_nor_cmd_seq;
    localparam int AW    = 24;
    localparam int DW    = 32;
    localparam int LIMIT = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_start = 1'b0, req_op = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          req_busy, req_done, mem_we, mem_re;
    logic [1:0]    req_result;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    always #4 clk = ~clk;

    nor_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .TIMEOUT_CYC(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_busy(req_busy),
        .req_done(req_done), .req_result(req_result), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_re(mem_re)
    );

    int checks = 0, errors = 0, cyc = 0, rd_cnt = 0, last_wr_cyc = 0;
    logic [AW+DW-1:0] exp_wq[$];
    string            exp_tag[$];
    logic [DW-1:0]    rd_q[$];
    logic [DW-1:0]    dflt_rd = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] cw(input logic [7:0] b);
        return {8'h00, b, 8'h00, b};
    endfunction

    task automatic expw(input logic [AW-1:0] a, input logic [DW-1:0] v, input string tag);
        exp_wq.push_back({a, v});
        exp_tag.push_back(tag);
    endtask

    // flash bus model and write comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            last_wr_cyc = cyc;
            if (exp_wq.size() == 0) begin
                chk(1'b0, "R2", "unexpected write", {8'h0, mem_addr, mem_wdata}, 64'h0);
            end else begin
                logic [AW+DW-1:0] e;
                string t;
                e = exp_wq.pop_front();
                t = exp_tag.pop_front();
                chk({mem_addr, mem_wdata} == e, t, "write addr/data",
                    {8'h0, mem_addr, mem_wdata}, {8'h0, e});
            end
        end
        if (rst_n && mem_re) begin
            rd_cnt++;
            mem_rdata = (rd_q.size() != 0) ? rd_q.pop_front() : dflt_rd;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic push_erase(input logic [AW-1:0] sec);
        expw(24'h001554, cw(8'hAA), "R2");
        expw(24'h000AA8, cw(8'h55), "R2");
        expw(24'h001554, cw(8'h80), "R3");
        expw(24'h001554, cw(8'hAA), "R3");
        expw(24'h000AA8, cw(8'h55), "R3");
        expw(sec,        cw(8'h30), "R3");
    endtask

    task automatic push_prog(input logic [AW-1:0] tgt, input logic [DW-1:0] v);
        expw(24'h001554, cw(8'hAA), "R2");
        expw(24'h000AA8, cw(8'h55), "R2");
        expw(24'h001554, cw(8'h20), "R4");
        expw(tgt,        cw(8'hA0), "R4");
        expw(tgt,        v,         "R4");
    endtask

    task automatic run_op(input logic op, input logic [AW-1:0] addr, input logic [DW-1:0] data,
                          input logic [1:0] exp_res, input int exp_rd, input string req,
                          input bit poke_busy, output int done_at);
        int waited = 0;
        rd_cnt = 0;
        @(negedge clk);
        req_op = op; req_addr = addr; req_data = data; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        chk(req_busy == 1'b1, "R10", "busy after start", 64'(req_busy), 64'd1);
        if (poke_busy) begin
            @(negedge clk);
            req_start = 1'b1; req_op = ~op; req_addr = 24'h000100;
            @(negedge clk);
            req_start = 1'b0;
        end
        while (!req_done && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        done_at = cyc;
        chk(req_done == 1'b1, req, "done seen", 64'(req_done), 64'd1);
        chk(req_result == exp_res, req, "result code", 64'(req_result), 64'(exp_res));
        @(negedge clk);
        chk(!req_done && !req_busy, "R9", "done single cycle then idle",
            64'({req_done, req_busy}), 64'd0);
        chk(exp_wq.size() == 0, req, "all expected writes issued", 64'(exp_wq.size()), 64'd0);
        chk(rd_cnt == exp_rd, "R11", "read count", 64'(rd_cnt), 64'(exp_rd));
        exp_wq.delete(); exp_tag.delete(); rd_q.delete();
    endtask

    initial begin
        int t;
        repeat (3) @(negedge clk);
        chk(!req_busy && !req_done && !mem_we && !mem_re, "R1", "state in reset",
            64'({req_busy, req_done, mem_we, mem_re}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!req_busy && !req_done && !mem_we && !mem_re, "R1", "state after reset",
            64'({req_busy, req_done, mem_we, mem_re}), 64'd0);

        // R5: halves finish in different polls, high latched; R10 start poke ignored
        push_erase(24'h020000); expw(24'h020000, cw(8'hF0), "R8");
        rd_q = '{32'h0000_0000, 32'h0080_0000, 32'h0000_0080};
        run_op(1'b0, 24'h020000, '0, 2'd0, 3, "R5", 1'b1, t);

        // R5: low fails while high completes, result 1
        push_erase(24'h040000); expw(24'h040000, cw(8'hF0), "R8");
        rd_q = '{32'h0080_0020};
        run_op(1'b0, 24'h040000, '0, 2'd1, 1, "R5", 1'b0, t);

        // R5: low fails first, polling continues until high resolves
        push_erase(24'h060000); expw(24'h060000, cw(8'hF0), "R8");
        rd_q = '{32'h0000_0020, 32'h0080_0000};
        run_op(1'b0, 24'h060000, '0, 2'd1, 2, "R5", 1'b0, t);

        // R4/R8: program ok, two polls then matching readback
        push_prog(24'h000404, 32'h12B4_5678); expw(24'h000404, cw(8'hF0), "R8");
        rd_q = '{32'hFFFF_FFFF, 32'h0000_0080, 32'h12B4_5678, 32'h12B4_5678};
        run_op(1'b1, 24'h000404, 32'h12B4_5678, 2'd0, 4, "R4", 1'b0, t);

        // R4: not erased, no writes, result 3
        rd_q = '{32'hFFFF_0000};
        run_op(1'b1, 24'h000800, 32'h0000_0001, 2'd3, 1, "R4", 1'b0, t);

        // R6: bit5 on low, confirming read still mismatched -> fail; high resumes polling
        push_prog(24'h000404, 32'h12B4_5678); expw(24'h000404, cw(8'hF0), "R8");
        rd_q = '{32'hFFFF_FFFF, 32'h0000_00A0, 32'h0000_0080, 32'h0080_0000, 32'h12B4_5678};
        run_op(1'b1, 24'h000404, 32'h12B4_5678, 2'd1, 5, "R6", 1'b0, t);

        // R6: bit5 on low, confirming read matches -> ok; unaligned address cleared (R4)
        push_prog(24'h000404, 32'h12B4_5678); expw(24'h000404, cw(8'hF0), "R8");
        rd_q = '{32'hFFFF_FFFF, 32'h0000_00A0, 32'h0000_0000, 32'h0080_0000, 32'h12B4_5678};
        run_op(1'b1, 24'h000407, 32'h12B4_5678, 2'd0, 5, "R6", 1'b0, t);

        // R8: readback mismatch gives device error
        push_prog(24'h000900, 32'h12B4_5678); expw(24'h000900, cw(8'hF0), "R8");
        rd_q = '{32'hFFFF_FFFF, 32'h12B4_5678, 32'h12B4_5679};
        run_op(1'b1, 24'h000900, 32'h12B4_5678, 2'd1, 3, "R8", 1'b0, t);

        // R7: status never resolves -> read-array write and timeout result
        push_erase(24'h080000); expw(24'h080000, cw(8'hF0), "R7");
        dflt_rd = '0;
        begin
            int wr_at;
            fork
                begin
                    wait (mem_we && mem_wdata == cw(8'h30));
                    @(negedge clk);
                end
            join_none
            run_op(1'b0, 24'h080000, '0, 2'd2, 21, "R7", 1'b0, t);
            wr_at = t;
        end
        chk(t - last_wr_cyc <= 4, "R7", "F0 written just before done", 64'(t - last_wr_cyc), 64'd4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule